// File: doc/BRIEF.md
# Unpacked BCD Adjust Unit

This block applies the four corrections used with one-digit-per-byte decimal arithmetic. It works on an accumulator split into a high byte and a low byte, plus a carry flag and an auxiliary-carry flag. The add-adjust and subtract-adjust follow a byte add or subtract. Both look at the low digit and the auxiliary carry to decide whether a decimal overflow happened and needs correcting. The multiply-adjust splits a product byte into quotient and remainder digits. The divide-adjust packs two digits back into one binary byte before a divide.

The base for the multiply-adjust and the divide-adjust is an 8-bit input. Callers normally pass 10. Passing 16 turns the multiply-adjust into a nibble splitter. The multiply-adjust runs on a bit-serial restoring divider, so it takes several cycles. All other operations finish one cycle after they are accepted. A `done` pulse marks every result. A base of zero on the multiply-adjust does not start the divider. It reports a divide error instead.

Top module: `bcd_adjust_unit`

## Requirements
- R1: After reset, `acc_out`, `cf_out`, `af_out`, `div_err`, `busy` and `done` are all 0.
- R2: Add-adjust (`op`=0). When the low digit `acc_in[3:0]` is above 9 or `af_in`=1, the low byte becomes `(acc_in[7:0]+6) & 0x0F`, the high byte is incremented by one with wrap, and `cf_out`=`af_out`=1.
- R3: Add-adjust with low digit ≤ 9 and `af_in`=0 keeps the high byte, reduces the low byte to `acc_in[3:0]`, and clears both flags, whatever `cf_in` is.
- R4: Subtract-adjust (`op`=1) uses the same condition as R2. When it holds, the low byte becomes `(acc_in[7:0]-6) & 0x0F`, the high byte is decremented by one with wrap, and both flags are set. Otherwise the result is as in R3.
- R5: Multiply-adjust (`op`=2) with a nonzero base puts `acc_in[7:0] / base` in the high byte and `acc_in[7:0] % base` in the low byte. It holds `busy` high and raises `done` exactly DATA_W+2 cycles after the accepting edge.
- R6: Multiply-adjust with base 16 puts the upper nibble of the low byte in the high byte and the lower nibble in the low byte.
- R7: Multiply-adjust with base 0 completes one cycle after the accepting edge. It raises `div_err` with `done` and returns `acc_in` unchanged.
- R8: Divide-adjust (`op`=3) completes one cycle after the accepting edge. The low byte becomes `(high*base + low) mod 256` and the high byte becomes 0.
- R9: Multiply-adjust and divide-adjust return `cf_in` and `af_in` unchanged on `cf_out` and `af_out`.
- R10: A `start` while `busy` is high is ignored. It produces no extra `done` and does not disturb the running result.
- R11: `div_err` is high only together with `done`. `done` is never high while `busy` is high. Add, subtract and divide adjusts complete with `div_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when not busy |
| op | input | 2 | 0 add-adjust, 1 subtract-adjust, 2 multiply-adjust, 3 divide-adjust |
| base | input | DATA_W | Base for multiply/divide adjust |
| acc_in | input | 2*DATA_W | Accumulator, high byte in upper half |
| cf_in | input | 1 | Carry flag in |
| af_in | input | 1 | Auxiliary-carry flag in |
| acc_out | output | 2*DATA_W | Registered result accumulator |
| cf_out | output | 1 | Carry flag result |
| af_out | output | 1 | Auxiliary-carry flag result |
| div_err | output | 1 | Zero-base error, pulses with done |
| busy | output | 1 | Multiply-adjust in progress |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that `op`, `base`, `acc_in` and the flags are stable and valid at the edge where `start` is sampled. They also assume that `start` is sampled with reset released. The timing properties assume that the divider is loaded only with a nonzero base, and the top-level gating guarantees this. The stimulus drives all inputs at the falling edge and holds them for a full cycle. It pulses `start` for one cycle and waits for each result before issuing the next operation. The one exception is a deliberate `start` during a busy multiply-adjust, which checks that the request is ignored.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
   typedef enum logic [1:0] {
      OP_ADD_ADJ = 2'd0,
      OP_SUB_ADJ = 2'd1,
      OP_MUL_ADJ = 2'd2,
      OP_DIV_ADJ = 2'd3
   } adj_op_e;
endpackage

// File: rtl/bcd_nibble_fix.sv
module bcd_nibble_fix #(
   parameter int DATA_W = 8
) (
   input  logic              sub_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   input  logic              af_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   output logic              flag_o
);
   localparam int            DIG_W = 4;
   localparam logic [DATA_W-1:0] SIX  = DATA_W'(6);
   localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
   localparam logic [DIG_W-1:0]  NINE = DIG_W'(9);

   logic              need;
   logic [DATA_W-1:0] lo_t;

   always_comb begin
      need = (lo_i[DIG_W-1:0] > NINE) || af_i;
      lo_t = sub_i ? (lo_i - SIX) : (lo_i + SIX);
      if (need) begin
         lo_o   = {{(DATA_W-DIG_W){1'b0}}, lo_t[DIG_W-1:0]};
         hi_o   = sub_i ? (hi_i - ONE) : (hi_i + ONE);
         flag_o = 1'b1;
      end else begin
         lo_o   = {{(DATA_W-DIG_W){1'b0}}, lo_i[DIG_W-1:0]};
         hi_o   = hi_i;
         flag_o = 1'b0;
      end
   end
endmodule

// File: rtl/bcd_base_mac.sv
module bcd_base_mac #(
   parameter int DATA_W        = 8,
   parameter bit SHIFT_ADD_MAC = 1'b0
) (
   input  logic [DATA_W-1:0] hi_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] base_i,
   output logic [DATA_W-1:0] sum_o
);
   localparam int PW = 2 * DATA_W;
   logic [PW-1:0] prod;

   generate
      if (SHIFT_ADD_MAC) begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (base_i[i]) prod = prod + (PW'(hi_i) << i);
            end
         end
      end else begin : g_direct
         assign prod = PW'(hi_i) * PW'(base_i);
      end
   endgenerate

   assign sum_o = prod[DATA_W-1:0] + lo_i;
endmodule

// File: rtl/bcd_seq_divider.sv
module bcd_seq_divider #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic              busy_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] quo_o,
   output logic [DATA_W-1:0] rem_o
);
   localparam int CW = $clog2(DATA_W + 1);
   localparam int RW = DATA_W + 1;

   logic [CW-1:0]     cnt;
   logic [RW-1:0]     rem_q;
   logic [DATA_W-1:0] quo_q;
   logic [DATA_W-1:0] den_q;
   logic [RW-1:0]     rem_sh;
   logic              fits;

   always_comb begin
      rem_sh = {rem_q[DATA_W-1:0], quo_q[DATA_W-1]};
      fits   = rem_sh >= RW'(den_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rem_q   <= '0;
         quo_q   <= '0;
         den_q   <= '0;
         busy_o  <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (load_i) begin
            cnt    <= CW'(DATA_W);
            rem_q  <= '0;
            quo_q  <= dividend_i;
            den_q  <= divisor_i;
            busy_o <= 1'b1;
         end else if (busy_o) begin
            rem_q <= fits ? (rem_sh - RW'(den_q)) : rem_sh;
            quo_q <= {quo_q[DATA_W-2:0], fits};
            cnt   <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               busy_o  <= 1'b0;
               valid_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q[DATA_W-1:0];

   // R5
   fall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> valid_o);
   // R5
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (rem_o < den_q));
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
   import bcd_adj_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit SHIFT_ADD_MAC = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          op,
   input  logic [DATA_W-1:0]   base,
   input  logic [2*DATA_W-1:0] acc_in,
   input  logic                cf_in,
   input  logic                af_in,
   output logic [2*DATA_W-1:0] acc_out,
   output logic                cf_out,
   output logic                af_out,
   output logic                div_err,
   output logic                busy,
   output logic                done
);
   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("bcd_adjust_unit: DATA_W must be even and at least 8");
      end
   endgenerate

   adj_op_e           op_e;
   logic              accept;
   logic [DATA_W-1:0] lo_in, hi_in;
   logic [DATA_W-1:0] lo_fix, hi_fix;
   logic              flag_fix;
   logic [DATA_W-1:0] mac_lo;
   logic              div_load, div_busy, div_valid;
   logic [DATA_W-1:0] div_quo, div_rem;
   logic              cf_h, af_h;

   assign op_e     = adj_op_e'(op);
   assign lo_in    = acc_in[DATA_W-1:0];
   assign hi_in    = acc_in[2*DATA_W-1:DATA_W];
   assign busy     = div_busy | div_valid;
   assign accept   = start && !busy;
   assign div_load = accept && (op_e == OP_MUL_ADJ) && (base != '0);

   bcd_nibble_fix #(.DATA_W(DATA_W)) u_fix (
      .sub_i (op_e == OP_SUB_ADJ),
      .lo_i  (lo_in),
      .hi_i  (hi_in),
      .af_i  (af_in),
      .lo_o  (lo_fix),
      .hi_o  (hi_fix),
      .flag_o(flag_fix)
   );

   bcd_base_mac #(.DATA_W(DATA_W), .SHIFT_ADD_MAC(SHIFT_ADD_MAC)) u_mac (
      .hi_i  (hi_in),
      .lo_i  (lo_in),
      .base_i(base),
      .sum_o (mac_lo)
   );

   bcd_seq_divider #(.DATA_W(DATA_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (div_load),
      .dividend_i(lo_in),
      .divisor_i (base),
      .busy_o    (div_busy),
      .valid_o   (div_valid),
      .quo_o     (div_quo),
      .rem_o     (div_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_out <= '0;
         cf_out  <= 1'b0;
         af_out  <= 1'b0;
         div_err <= 1'b0;
         done    <= 1'b0;
         cf_h    <= 1'b0;
         af_h    <= 1'b0;
      end else begin
         done    <= 1'b0;
         div_err <= 1'b0;
         if (accept) begin
            case (op_e)
               OP_ADD_ADJ, OP_SUB_ADJ: begin
                  acc_out <= {hi_fix, lo_fix};
                  cf_out  <= flag_fix;
                  af_out  <= flag_fix;
                  done    <= 1'b1;
               end
               OP_MUL_ADJ: begin
                  cf_h <= cf_in;
                  af_h <= af_in;
                  if (base == '0) begin
                     acc_out <= acc_in;
                     cf_out  <= cf_in;
                     af_out  <= af_in;
                     div_err <= 1'b1;
                     done    <= 1'b1;
                  end
               end
               default: begin
                  acc_out <= {{DATA_W{1'b0}}, mac_lo};
                  cf_out  <= cf_in;
                  af_out  <= af_in;
                  done    <= 1'b1;
               end
            endcase
         end else if (div_valid) begin
            acc_out <= {div_quo, div_rem};
            cf_out  <= cf_h;
            af_out  <= af_h;
            done    <= 1'b1;
         end
      end
   end

   // R7
   zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_e == OP_MUL_ADJ && base == '0) |=> (done && div_err));
   // R8
   quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_e != OP_MUL_ADJ) |=> (done && !div_err));
   // R5
   mul_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_e == OP_MUL_ADJ && base != '0) |=> (busy && !done));
   // R11
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);
   // R11
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |-> done);
endmodule

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   typedef struct {
      logic [2*W-1:0] acc;
      logic           cf;
      logic           af;
      logic           err;
      int             lat;
      int             cyc0;
      string          req;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [1:0]     op = '0;
   logic [W-1:0]   base = '0;
   logic [2*W-1:0] acc_in = '0;
   logic           cf_in = 1'b0, af_in = 1'b0;
   logic [2*W-1:0] acc_out;
   logic           cf_out, af_out, div_err, busy, done;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bcd_adjust_unit #(.DATA_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base(base),
      .acc_in(acc_in), .cf_in(cf_in), .af_in(af_in), .acc_out(acc_out),
      .cf_out(cf_out), .af_out(af_out), .div_err(div_err), .busy(busy),
      .done(done)
   );

   function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] b,
                                  input logic [2*W-1:0] a, input logic c,
                                  input logic f);
      exp_t e;
      logic [W-1:0] lo = a[W-1:0];
      logic [W-1:0] hi = a[2*W-1:W];
      int           t;
      e.err = 1'b0; e.lat = 1; e.cf = c; e.af = f; e.acc = a;
      case (o)
         2'd0, 2'd1: begin
            if (lo[3:0] > 4'd9 || f) begin
               if (o == 2'd0) begin lo = lo + 8'd6; hi = hi + 8'd1; end
               else           begin lo = lo - 8'd6; hi = hi - 8'd1; end
               e.cf = 1'b1; e.af = 1'b1;
            end else begin
               e.cf = 1'b0; e.af = 1'b0;
            end
            e.acc = {hi, 4'h0, lo[3:0]};
         end
         2'd2: begin
            if (b == 0) e.err = 1'b1;
            else begin
               e.acc = {8'(lo / b), 8'(lo % b)};
               e.lat = W + 2;
            end
         end
         default: begin
            t = int'(hi) * int'(b) + int'(lo);
            e.acc = {8'h00, 8'(t % 256)};
         end
      endcase
      return e;
   endfunction

   task automatic issue(input logic [1:0] o, input logic [W-1:0] b,
                        input logic [2*W-1:0] a, input logic c,
                        input logic f, input string r);
      exp_t e;
      e = model(o, b, a, c, f);
      e.cyc0 = cyc;
      e.req = r;
      q.push_back(e);
      op = o; base = b; acc_in = a; cf_in = c; af_in = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL R10: actual unexpected done acc=%h, expected no completion", acc_out);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (acc_out !== e.acc || cf_out !== e.cf || af_out !== e.af ||
                div_err !== e.err || (cyc - e.cyc0) != e.lat) begin
               errors++;
               $display("FAIL %s: actual acc=%h cf=%b af=%b err=%b lat=%0d, expected acc=%h cf=%b af=%b err=%b lat=%0d",
                        e.req, acc_out, cf_out, af_out, div_err, cyc - e.cyc0,
                        e.acc, e.cf, e.af, e.err, e.lat);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R5: actual no completion, expected completion before watchdog");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (acc_out !== '0 || cf_out !== 1'b0 || af_out !== 1'b0 ||
          div_err !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
         errors++;
         $display("FAIL R1: actual acc=%h cf=%b af=%b err=%b busy=%b done=%b, expected all zero",
                  acc_out, cf_out, af_out, div_err, busy, done);
      end
      rst_n = 1'b1;
      @(negedge clk);

      issue(2'd0, 8'd10, 16'h000C, 1'b0, 1'b0, "R2"); drain();
      issue(2'd0, 8'd10, 16'h0512, 1'b0, 1'b1, "R2"); drain();
      issue(2'd0, 8'd10, 16'hFF0A, 1'b0, 1'b0, "R2"); drain();
      issue(2'd0, 8'd10, 16'h03A7, 1'b1, 1'b0, "R3"); drain();
      issue(2'd1, 8'd10, 16'h02FF, 1'b0, 1'b0, "R4"); drain();
      issue(2'd1, 8'd10, 16'h000B, 1'b0, 1'b0, "R4"); drain();
      issue(2'd1, 8'd10, 16'h0703, 1'b1, 1'b1, "R4"); drain();
      issue(2'd1, 8'd10, 16'h04C5, 1'b1, 1'b0, "R4"); drain();
      issue(2'd2, 8'd10, 16'h3F51, 1'b1, 1'b0, "R5"); drain();
      issue(2'd2, 8'd7,  16'h00C8, 1'b0, 1'b1, "R9"); drain();
      issue(2'd2, 8'd255,16'h00FE, 1'b0, 1'b0, "R5"); drain();
      issue(2'd2, 8'd200,16'h00FA, 1'b1, 1'b1, "R5"); drain();
      issue(2'd2, 8'd16, 16'h00B7, 1'b0, 1'b0, "R6"); drain();
      issue(2'd2, 8'd0,  16'h1234, 1'b1, 1'b0, "R7"); drain();
      issue(2'd3, 8'd10, 16'h0709, 1'b0, 1'b1, "R8"); drain();
      issue(2'd3, 8'd16, 16'h0B07, 1'b1, 1'b1, "R9"); drain();
      issue(2'd3, 8'd10, 16'h1905, 1'b0, 1'b0, "R8"); drain();
      issue(2'd3, 8'd10, 16'h3030, 1'b0, 1'b0, "R8"); drain();

      // R10: start during a busy multiply-adjust is ignored
      issue(2'd2, 8'd10, 16'h0063, 1'b0, 1'b0, "R10");
      repeat (2) @(negedge clk);
      op = 2'd0; acc_in = 16'h00FF; af_in = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule